// File: doc/BRIEF.md
# Three-Row Window Sweep Sequencer

This block sequences a line store of three row buffers, each holding one image row of `COLS` pixels, for a bank of parallel weighted-sum units that all see the same 3×3 window at once. It requests image rows from the sensor side one at a time and fills the three buffers. It then sweeps a 3×3 window across the columns. Each window is held stable for a fixed number of clock cycles so that the analog weighted sum can settle. After the last column position it requests the next image row. That row goes into the buffer holding the oldest row, so no data is copied between buffers. The kernel-row routing rotates so that kernel row 0 always reads the oldest stored row.

The sequencer drives a per-cell read-enable vector over all three buffers, a kernel-row to buffer mapping, the current window column, a level window-valid signal and a first-cycle window pulse. It also drives a row-load request that waits for an acknowledge. A frame begins on a start pulse and ends with a one-cycle frame-done pulse after the last window that uses image row `ROWS-1`.

States: `ST_IDLE` (waiting for a start), `ST_FILL` (loading the first three rows), `ST_SWEEP` (presenting windows), `ST_REFILL` (loading one replacement row), `ST_DONE` (one-cycle end of frame).

Transitions:
- IDLE→FILL on `frame_start`.
- FILL→FILL on each acknowledge of the first two rows.
- FILL→SWEEP on the third acknowledge.
- SWEEP→REFILL at the end of the last window of a row set while rows remain.
- SWEEP→DONE at that point once all rows are loaded.
- REFILL→SWEEP on acknowledge.
- DONE→IDLE always.

Top module: `tri_row_sweep_seq`

## Requirements
- R1: After reset, and in idle, `load_req`, `win_valid`, `win_new` and `frame_done` are 0, `cell_ren` is all zero, and `ksel` maps kernel row k to buffer k. A `frame_start` seen in idle begins a frame on the next clock.
- R2: A frame first requests image rows 0, 1 and 2 into buffers 0, 1 and 2, in that order. `load_req` stays high, with `load_row` and `load_buf` stable, until `load_ack` is sampled high. No window is shown before the third acknowledge.
- R3: Each window keeps `win_valid` high and `win_col` unchanged for exactly `HOLD` cycles. `win_new` is high only in the first of those cycles. `win_col` is meaningful only while `win_valid` is high.
- R4: Within one row set the windows take columns 0, 1, …, `COLS-3` in ascending order, with no gaps and no padding. The first window starts on the clock after the acknowledge that completes a load.
- R5: Bit `b*COLS+c` of `cell_ren` is high exactly when `win_valid` is high and `win_col ≤ c ≤ win_col+2`, for every buffer b in 0..2.
- R6: After the last window of a row set, while image rows remain, one row is requested. `load_buf` is the buffer holding the oldest row and `load_row` is the next image row index. No window is shown until that request is acknowledged.
- R7: Field k of `ksel` (bits 2k+1:2k) equals (oldest + k) mod 3, where oldest is the buffer of the oldest stored row. Oldest is 0 at frame start and advances by one, modulo 3, on each replacement-row acknowledge.
- R8: After the last window of the row set ending in image row `ROWS-1`, `frame_done` is high for one cycle and the block returns to idle. A frame shows (ROWS-2)·(COLS-2) windows and accepts `ROWS` loads.
- R9: `load_ack` while no load is requested, and `frame_start` outside idle, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start of a frame, taken only in idle |
| load_ack | input | 1 | Requested row has been written |
| load_req | output | 1 | Row load requested |
| load_buf | output | 2 | Target buffer of the requested row |
| load_row | output | $clog2(ROWS) | Image row index to load |
| win_valid | output | 1 | A window is being presented |
| win_new | output | 1 | First cycle of a window |
| win_col | output | $clog2(COLS) | Leftmost column of the window |
| ksel | output | 6 | Buffer index per kernel row, 2 bits each |
| cell_ren | output | 3*COLS | Per-cell read enables, buffer-major |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two events can land in the same cycle. The first is the end of the final window of a row set together with the start of a row request or frame-done. The second is a load request together with an acknowledge that arrives in the very cycle the request first appears. The bench provokes the second with a zero-delay acknowledge policy on one frame. On the other frames it uses later acknowledges, spurious acknowledges, and start pulses asserted during the sweep and during the frame-done cycle. A behavioural model advanced on every clock judges each output field every cycle. Frame totals of windows, loads and done pulses are also checked against the counts the requirements give.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;

    localparam int TWS_NBUF = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SWEEP,
        ST_REFILL,
        ST_DONE
    } tws_state_e;

    // (a + k) mod 3 for a buffer index a in 0..2
    function automatic logic [1:0] wrap3(input logic [1:0] a, input int k);
        int s;
        s = (int'(a) + k) % TWS_NBUF;
        return 2'(s);
    endfunction

endpackage

// File: rtl/tws_col_timer.sv
`timescale 1ns/1ps
module tws_col_timer #(
    parameter int COLS  = 320,
    parameter int HOLD  = 18,
    localparam int COL_W  = $clog2(COLS),
    localparam int HOLD_W = $clog2(HOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    output logic [COL_W-1:0] col_o,
    output logic             hold_first_o,
    output logic             hold_last_o,
    output logic             col_last_o
);

    logic [COL_W-1:0]  col_q;
    logic [HOLD_W-1:0] hold_q;

    assign hold_first_o = (hold_q == '0);
    assign hold_last_o  = (hold_q == HOLD_W'(HOLD - 1));
    assign col_last_o   = (col_q == COL_W'(COLS - 3));
    assign col_o        = col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            hold_q <= '0;
        end else if (start_i) begin
            col_q  <= '0;
            hold_q <= '0;
        end else if (run_i) begin
            if (hold_last_o) begin
                if (!col_last_o) begin
                    col_q  <= col_q + 1'b1;
                    hold_q <= '0;
                end
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(col_q) <= COLS - 3) else $error("column out of range"); // R4

    AST_COL_STABLE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && !hold_last_o) |=> $stable(col_q)) else $error("column moved inside hold"); // R3

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && hold_last_o && !col_last_o) |=>
            (hold_q == '0) && (col_q == COL_W'($past(col_q) + 1'b1))) else $error("column step wrong"); // R4

endmodule

// File: rtl/tws_row_rotator.sv
`timescale 1ns/1ps
module tws_row_rotator
    import tws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       adv_i,
    output logic [1:0] oldest_o,
    output logic [5:0] ksel_o
);

    logic [1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= 2'd0;
        end else if (clear_i) begin
            base_q <= 2'd0;
        end else if (adv_i) begin
            base_q <= wrap3(base_q, 1);
        end
    end

    assign oldest_o = base_q;

    for (genvar k = 0; k < TWS_NBUF; k++) begin : g_krow
        assign ksel_o[2*k +: 2] = wrap3(base_q, k);
    end

    AST_BASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        base_q <= 2'd2) else $error("oldest pointer out of range"); // R7

    AST_SEL_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (ksel_o[1:0] != ksel_o[3:2]) && (ksel_o[1:0] != ksel_o[5:4]) && (ksel_o[3:2] != ksel_o[5:4]))
        else $error("kernel rows share a buffer"); // R7

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clear_i) |=> $stable(base_q)) else $error("rotation without advance"); // R7

endmodule

// File: rtl/tws_ren_decoder.sv
`timescale 1ns/1ps
module tws_ren_decoder
    import tws_pkg::*;
#(
    parameter int COLS = 320,
    localparam int COL_W = $clog2(COLS),
    localparam int REN_W = TWS_NBUF * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [COL_W-1:0] col_i,
    output logic [REN_W-1:0] cell_ren_o
);

    logic [COLS-1:0] hit;

    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            hit[c] = valid_i && (c >= int'(col_i)) && (c <= int'(col_i) + 2);
        end
    end

    for (genvar b = 0; b < TWS_NBUF; b++) begin : g_buf
        assign cell_ren_o[b*COLS +: COLS] = hit;
    end

    AST_REN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> ($countones(cell_ren_o) == 3 * TWS_NBUF)) else $error("window not 3x3"); // R5

    AST_REN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (cell_ren_o == '0)) else $error("enable without window"); // R5

endmodule

// File: rtl/tri_row_sweep_seq.sv
`timescale 1ns/1ps
module tri_row_sweep_seq
    import tws_pkg::*;
#(
    parameter int COLS = 320,
    parameter int ROWS = 240,
    parameter int HOLD = 18,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS),
    localparam int CNT_W = $clog2(ROWS + 1),
    localparam int REN_W = TWS_NBUF * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             load_ack,
    output logic             load_req,
    output logic [1:0]       load_buf,
    output logic [ROW_W-1:0] load_row,
    output logic             win_valid,
    output logic             win_new,
    output logic [COL_W-1:0] win_col,
    output logic [5:0]       ksel,
    output logic [REN_W-1:0] cell_ren,
    output logic             frame_done
);

    tws_state_e state_q, state_d;

    logic [1:0]       fill_cnt_q;
    logic [CNT_W-1:0] next_row_q;
    logic             tmr_start, tmr_run;
    logic             hold_first, hold_last, col_last;
    logic             rot_clear, rot_adv;
    logic [1:0]       oldest;
    logic             fill_done, rows_left;

    assign fill_done = (fill_cnt_q == 2'd2);
    assign rows_left = (next_row_q != CNT_W'(ROWS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and internal controls
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        tmr_run   = 1'b0;
        rot_clear = 1'b0;
        rot_adv   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) begin
                    state_d   = ST_FILL;
                    rot_clear = 1'b1;
                end
            end
            ST_FILL: begin
                if (load_ack && fill_done) begin
                    state_d   = ST_SWEEP;
                    tmr_start = 1'b1;
                end
            end
            ST_SWEEP: begin
                tmr_run = 1'b1;
                if (hold_last && col_last) begin
                    state_d = rows_left ? ST_REFILL : ST_DONE;
                end
            end
            ST_REFILL: begin
                if (load_ack) begin
                    state_d   = ST_SWEEP;
                    tmr_start = 1'b1;
                    rot_adv   = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // row bookkeeping for loads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt_q <= 2'd0;
            next_row_q <= '0;
        end else if (state_q == ST_IDLE && frame_start) begin
            fill_cnt_q <= 2'd0;
            next_row_q <= '0;
        end else if ((state_q == ST_FILL || state_q == ST_REFILL) && load_ack) begin
            next_row_q <= next_row_q + 1'b1;
            if (state_q == ST_FILL) fill_cnt_q <= fill_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_req   = 1'b0;
        load_buf   = oldest;
        win_valid  = 1'b0;
        win_new    = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FILL: begin
                load_req = 1'b1;
                load_buf = fill_cnt_q;
            end
            ST_SWEEP: begin
                win_valid = 1'b1;
                win_new   = hold_first;
            end
            ST_REFILL: begin
                load_req = 1'b1;
                load_buf = oldest;
            end
            ST_DONE: frame_done = 1'b1;
            default: ;
        endcase
    end

    assign load_row = next_row_q[ROW_W-1:0];

    tws_col_timer #(.COLS(COLS), .HOLD(HOLD)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (tmr_start),
        .run_i        (tmr_run),
        .col_o        (win_col),
        .hold_first_o (hold_first),
        .hold_last_o  (hold_last),
        .col_last_o   (col_last)
    );

    tws_row_rotator u_rot (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (rot_clear),
        .adv_i    (rot_adv),
        .oldest_o (oldest),
        .ksel_o   (ksel)
    );

    tws_ren_decoder #(.COLS(COLS)) u_ren (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (win_valid),
        .col_i      (win_col),
        .cell_ren_o (cell_ren)
    );

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !load_ack) |=> (load_req && $stable(load_row) && $stable(load_buf)))
        else $error("request dropped or changed"); // R2

    AST_NO_WIN_DURING_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> !win_valid) else $error("window during load"); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !load_req && !win_valid)) else $error("done not a pulse"); // R8

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_start) |=> (state_q == ST_IDLE)) else $error("left idle unasked"); // R1

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP && !(hold_last && col_last)) |=> (state_q == ST_SWEEP)) else $error("sweep disturbed"); // R9

endmodule

// File: tb/tri_row_sweep_seq_tb.sv
`timescale 1ns/1ps
module tri_row_sweep_seq_tb_top;

    localparam int C  = 8;
    localparam int R  = 6;
    localparam int H  = 3;
    localparam int CW = $clog2(C);
    localparam int RW = $clog2(R);

    localparam int M_IDLE = 0, M_FILL = 1, M_SWEEP = 2, M_REFILL = 3, M_DONE = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic frame_start, load_ack;
    logic load_req, win_valid, win_new, frame_done;
    logic [1:0] load_buf;
    logic [RW-1:0] load_row;
    logic [CW-1:0] win_col;
    logic [5:0] ksel;
    logic [3*C-1:0] cell_ren;

    tri_row_sweep_seq #(.COLS(C), .ROWS(R), .HOLD(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .load_ack(load_ack),
        .load_req(load_req), .load_buf(load_buf), .load_row(load_row),
        .win_valid(win_valid), .win_new(win_new), .win_col(win_col),
        .ksel(ksel), .cell_ren(cell_ren), .frame_done(frame_done)
    );

    always #5 clk = ~clk;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    // behavioural reference model
    int m_mode, m_loaded, m_next, m_oldest, m_col, m_hold;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = M_IDLE; m_loaded = 0; m_next = 0; m_oldest = 0; m_col = 0; m_hold = 0;
        end else begin
            case (m_mode)
                M_IDLE: if (frame_start) begin
                    m_mode = M_FILL; m_loaded = 0; m_next = 0; m_oldest = 0;
                end
                M_FILL: if (load_ack) begin
                    m_next++; m_loaded++;
                    if (m_loaded == 3) begin m_mode = M_SWEEP; m_col = 0; m_hold = 0; end
                end
                M_SWEEP: begin
                    if (m_hold == H - 1) begin
                        if (m_col == C - 3) m_mode = (m_next == R) ? M_DONE : M_REFILL;
                        else begin m_col++; m_hold = 0; end
                    end else m_hold++;
                end
                M_REFILL: if (load_ack) begin
                    m_oldest = (m_oldest + 1) % 3; m_next++;
                    m_mode = M_SWEEP; m_col = 0; m_hold = 0;
                end
                default: m_mode = M_IDLE;
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    int seen_windows, seen_loads, seen_done;

    task automatic compare_all();
        logic [5:0] eks;
        logic [3*C-1:0] eren;
        bit sw, ld;
        sw = (m_mode == M_SWEEP);
        ld = (m_mode == M_FILL) || (m_mode == M_REFILL);
        for (int k = 0; k < 3; k++) eks[2*k +: 2] = 2'((m_oldest + k) % 3);
        for (int b = 0; b < 3; b++)
            for (int c = 0; c < C; c++)
                eren[b*C + c] = sw && (c >= m_col) && (c <= m_col + 2);
        check(load_req === ld, "R2/R6 load_req", 64'(load_req), 64'(ld));
        if (ld) begin
            check(load_buf === 2'((m_mode == M_FILL) ? m_loaded : m_oldest), "R2/R6 load_buf",
                  64'(load_buf), 64'((m_mode == M_FILL) ? m_loaded : m_oldest));
            check(load_row === RW'(m_next), "R2/R6 load_row", 64'(load_row), 64'(m_next));
        end
        check(win_valid === sw, "R3/R4 win_valid", 64'(win_valid), 64'(sw));
        check(win_new === (sw && m_hold == 0), "R3 win_new", 64'(win_new), 64'(sw && m_hold == 0));
        if (sw) check(win_col === CW'(m_col), "R4 win_col", 64'(win_col), 64'(m_col));
        check(ksel === eks, "R7 ksel", 64'(ksel), 64'(eks));
        check(cell_ren === eren, "R5 cell_ren", 64'(cell_ren), 64'(eren));
        check(frame_done === (m_mode == M_DONE), "R8 frame_done", 64'(frame_done), 64'(m_mode == M_DONE));
        if (win_new) seen_windows++;
        if (frame_done) seen_done++;
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_frame(input int ack_delay, input bit noisy);
        int age = 0;
        int cyc = 0;
        bit ended = 0;
        seen_windows = 0; seen_loads = 0; seen_done = 0;
        frame_start = 1'b1; load_ack = 1'b0;
        while (!ended) begin
            tick();
            cyc++;
            if (m_mode == M_DONE) ended = 1;
            if (m_mode == M_FILL || m_mode == M_REFILL) begin
                if (age >= ack_delay) begin load_ack = 1'b1; age = 0; seen_loads++; end
                else begin load_ack = 1'b0; age++; end
            end else begin
                load_ack = noisy && (cyc % 7 == 3);       // R9 stray acknowledges
            end
            // R9: start pulses outside idle, including the frame-done cycle
            frame_start = (m_mode == M_DONE) || (noisy && m_mode == M_SWEEP && cyc % 5 == 1);
            if (cyc > 5000) ended = 1;
        end
        for (int i = 0; i < 4; i++) begin
            tick();
            frame_start = 1'b0;
            load_ack = noisy && (i == 1);
            check(!load_req && !win_valid, "R1/R9 stays idle after done",
                  64'({load_req, win_valid}), 64'd0);
        end
        load_ack = 1'b0;
        check(seen_windows == (R - 2) * (C - 2), "R8 window total", 64'(seen_windows), 64'((R - 2) * (C - 2)));
        check(seen_loads == R, "R8 load total", 64'(seen_loads), 64'(R));
        check(seen_done == 1, "R8 done pulses", 64'(seen_done), 64'd1);
    endtask

    initial begin
        rst_n = 1'b0; frame_start = 1'b0; load_ack = 1'b0;
        repeat (3) tick();
        check(!load_req && !win_valid && cell_ren == '0 && !frame_done && ksel == 6'b10_01_00,
              "R1 reset state", 64'({load_req, win_valid, frame_done, ksel}), 64'({3'b000, 6'b10_01_00}));
        rst_n = 1'b1;
        tick();
        load_ack = 1'b1;                                  // R9 ack in idle
        tick();
        load_ack = 1'b0;
        tick();
        check(!load_req && !win_valid, "R9 idle ack ignored", 64'({load_req, win_valid}), 64'd0);
        run_frame(0, 1'b0);                               // same-cycle acknowledge
        run_frame(2, 1'b1);                               // late acks, stray inputs
        run_frame(5, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule